// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on an audio converter's master clock and works out how many master-clock cycles fit in one period of the frame (word-select) clock. The frame clock is asynchronous to the logic. It is synchronized, and the cycles between successive rising edges are counted. Each count is matched against seven supported ratios with a small tolerance. The block then reports which ratio was found, and it chooses the sampling speed mode (normal, double or quad) that the interpolation and modulator clocking downstream should use. The ratio code also serves as the divide selector for the internal clock.

An auto-select input chooses between automatic detection and a manual mode. In manual mode the speed is forced to normal and only the slow ratios are accepted. A lock filter makes the reported values steady: a ratio must be measured twice in a row before it is reported, and it must be missed twice in a row before it is withdrawn. After reset the block signals power-down until the first frame-clock rising edge arrives, because the internal frame timing starts from that edge.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While and right after reset: pwr_down=1, locked=0, ratio_code=0 and speed_mode=0.
- R2: pwr_down stays 1 after reset until the first synchronized frame_clk rising edge, then drops to 0 and stays 0 until the next reset.
- R3: A measurement is the number of master-clock cycles between two successive frame_clk rising edges. The first edge after reset only starts timing and yields no measurement.
- R4: Ratio codes are 1=128, 2=192, 3=256, 4=384, 5=512, 6=768 and 7=1152 cycles per frame. A count within plus or minus 2 of a nominal value matches it, and any other count is unsupported.
- R5: With auto_sel=1 and lock held, speed_mode is 2 (quad) for codes 1 and 2, 1 (double) for codes 3 and 4, and 0 (normal) for codes 5 to 7.
- R6: With auto_sel=0, speed_mode is always 0, and counts near 128 or 192 are unsupported.
- R7: locked rises after two consecutive measurements that give the same supported code. While locked, ratio_code holds that code.
- R8: While locked, a single measurement that does not match the locked code is ignored. Two consecutive non-matching measurements clear locked, and while unlocked ratio_code=0 and speed_mode=0.
- R9: The period counter saturates instead of wrapping. A frame longer than the counter range is unsupported, even if its length modulo the counter range lands on a supported ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock, asynchronous to mclk |
| auto_sel | input | 1 | 1 = automatic ratio and speed detection, 0 = forced normal speed |
| ratio_code | output | 3 | Locked ratio code (0 = none, 1..7 as in R4) |
| speed_mode | output | 2 | 0 normal, 1 double, 2 quad |
| locked | output | 1 | A ratio has been measured consistently |
| pwr_down | output | 1 | High until frame-clock activity is seen after reset |

## Verification
The bench sweeps every supported ratio in both modes and checks each against a table of codes and speeds computed in the bench. It probes the tolerance edge at exactly two cycles off and at three cycles off, where an off-by-one comparison would either accept a wrong clock or reject a good one. It steps one frame at a time through lock and unlock, to catch a filter that acts on one measurement or needs three. It also checks that a single glitch frame does not drop lock. A frame of 2560 cycles is used because a wrapping counter would read it as 512 and lock falsely. Manual mode with 128 and 192 ratios is also applied, and a design that forgot to reject those ratios would lock onto them.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  localparam int NUM_RATIOS = 7;
  localparam int CODE_W     = 3;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_t;

  // Nominal master clocks per frame for each ratio code (1..7).
  function automatic int nominal_ratio(input int idx);
    case (idx)
      1:       return 128;
      2:       return 192;
      3:       return 256;
      4:       return 384;
      5:       return 512;
      6:       return 768;
      7:       return 1152;
      default: return 0;
    endcase
  endfunction

  function automatic speed_t speed_of(input logic [CODE_W-1:0] code);
    if (code == 3'd1 || code == 3'd2)      return SPD_QUAD;
    else if (code == 3'd3 || code == 3'd4) return SPD_DOUBLE;
    else                                   return SPD_NORMAL;
  endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Rising edge seen between the last synchronized stage and its delayed copy.
  assign rise_o = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (tick) begin
      cnt_d  = '0;
      seen_d = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  // Cycles since previous edge, inclusive of this one; saturates at CNT_MAX.
  assign meas_count = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign meas_valid = tick & seen_q;
endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]  count,
  input  logic              auto_sel,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 1; i <= NUM_RATIOS; i++) begin
      int diff;
      diff = int'(count) - nominal_ratio(i);
      if (diff <= TOL && diff >= -TOL && (auto_sel || i >= 3))
        code = CODE_W'(i);
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic       auto_sel,
  output logic [2:0] ratio_code,
  output logic [1:0] speed_mode,
  output logic       locked,
  output logic       pwr_down
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q[1];

  logic              rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas_count;
  logic [CODE_W-1:0] code;

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_int_n), .async_in(frame_clk), .rise_o(rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(mclk), .rst_n(rst_int_n), .tick(rise),
    .meas_valid(meas_valid), .meas_count(meas_count)
  );

  mrd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .count(meas_count), .auto_sel(auto_sel), .code(code)
  );

  // Lock filter state.
  logic [CODE_W-1:0] cand_q, cand_d, lcode_q, lcode_d;
  logic [1:0]        good_q, good_d, bad_q, bad_d;
  logic              lock_q, lock_d, pd_q, pd_d;

  always_comb begin
    cand_d  = cand_q;
    good_d  = good_q;
    bad_d   = bad_q;
    lock_d  = lock_q;
    lcode_d = lcode_q;
    pd_d    = pd_q;
    if (rise) pd_d = 1'b0;
    if (meas_valid) begin
      cand_d = code;
      if (code == '0)          good_d = 2'd0;
      else if (code == cand_q) good_d = (good_q == 2'd2) ? 2'd2 : good_q + 2'd1;
      else                     good_d = 2'd1;
      if (lock_q) begin
        if (code == lcode_q) begin
          bad_d = 2'd0;
        end else if (bad_q == 2'd1) begin
          lock_d  = 1'b0;
          lcode_d = '0;
          bad_d   = 2'd0;
        end else begin
          bad_d = 2'd1;
        end
      end else if (good_d == 2'd2) begin
        lock_d  = 1'b1;
        lcode_d = code;
        bad_d   = 2'd0;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cand_q  <= '0;
      good_q  <= 2'd0;
      bad_q   <= 2'd0;
      lock_q  <= 1'b0;
      lcode_q <= '0;
      pd_q    <= 1'b1;
    end else begin
      cand_q  <= cand_d;
      good_q  <= good_d;
      bad_q   <= bad_d;
      lock_q  <= lock_d;
      lcode_q <= lcode_d;
      pd_q    <= pd_d;
    end
  end

  assign ratio_code = lcode_q;
  assign locked     = lock_q;
  assign pwr_down   = pd_q;
  assign speed_mode = (lock_q && auto_sel) ? speed_of(lcode_q) : SPD_NORMAL;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic       mclk,
  input logic       rst_n,
  input logic       auto_sel,
  input logic [2:0] ratio_code,
  input logic [1:0] speed_mode,
  input logic       locked,
  input logic       pwr_down
);
  assert_pd_sticky_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    !pwr_down |=> !pwr_down);

  assert_lock_after_wake_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> !pwr_down);

  assert_code_valid_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> (ratio_code != 3'd0));

  assert_code_hold_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ratio_code));

  assert_unlocked_clear_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    !locked |-> (ratio_code == 3'd0 && speed_mode == 2'd0));

  assert_manual_normal_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    !auto_sel |-> (speed_mode == 2'd0));

  assert_quad_map_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && auto_sel && ratio_code <= 3'd2) |-> (speed_mode == 2'd2));

  assert_speed_legal_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    speed_mode != 2'd3);
endmodule

bind mclk_ratio_detect mrd_checker u_mrd_checker (
  .mclk(mclk), .rst_n(rst_n), .auto_sel(auto_sel), .ratio_code(ratio_code),
  .speed_mode(speed_mode), .locked(locked), .pwr_down(pwr_down)
);

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;
  logic       mclk = 1'b0;
  logic       rst_n;
  logic       frame_clk;
  logic       auto_sel;
  logic [2:0] ratio_code;
  logic [1:0] speed_mode;
  logic       locked;
  logic       pwr_down;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 mclk = ~mclk;

  mclk_ratio_detect dut (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk), .auto_sel(auto_sel),
    .ratio_code(ratio_code), .speed_mode(speed_mode), .locked(locked),
    .pwr_down(pwr_down)
  );

  int noms[7] = '{128, 192, 256, 384, 512, 768, 1152};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frames(input int r, input int n);
    for (int k = 0; k < n; k++) begin
      frame_clk = 1'b1;
      repeat (r / 2) @(negedge mclk);
      frame_clk = 1'b0;
      repeat (r - r / 2) @(negedge mclk);
    end
  endtask

  function automatic int exp_speed(input int r, input bit au);
    if (!au || r >= 512) return 0;
    if (r >= 256) return 1;
    return 2;
  endfunction

  initial begin
    rst_n = 1'b0; frame_clk = 1'b0; auto_sel = 1'b1;
    repeat (4) @(negedge mclk);
    // R1 reset values
    check(pwr_down == 1 && locked == 0, "R1 reset pd/lock", {pwr_down, locked}, 2);
    check(ratio_code == 0 && speed_mode == 0, "R1 reset code/speed", {ratio_code, speed_mode}, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge mclk);
    check(pwr_down == 1, "R2 pd before frame edge", pwr_down, 1);
    frames(512, 1);
    check(pwr_down == 0, "R2 pd after first edge", pwr_down, 0);
    check(locked == 0, "R3 no lock from one edge", locked, 0);

    // R4 R5 R7: auto sweep over all ratios
    for (int i = 0; i < 7; i++) begin
      frames(noms[i], 8);
      check(locked == 1, $sformatf("R7 lock auto r=%0d", noms[i]), locked, 1);
      check(ratio_code == i + 1, $sformatf("R4 code auto r=%0d", noms[i]), ratio_code, i + 1);
      check(speed_mode == exp_speed(noms[i], 1), $sformatf("R5 speed r=%0d", noms[i]),
            speed_mode, exp_speed(noms[i], 1));
    end

    // R4 tolerance
    frames(514, 8);
    check(locked == 1 && ratio_code == 5, "R4 tol +2", ratio_code, 5);
    frames(382, 8);
    check(locked == 1 && ratio_code == 4, "R4 tol -2", ratio_code, 4);
    frames(515, 8);
    check(locked == 0 && ratio_code == 0, "R4 tol +3 unsupported", ratio_code, 0);

    // R7 lock timing, one frame at a time
    frames(256, 2);
    check(locked == 0, "R7 one match no lock", locked, 0);
    frames(256, 1);
    check(locked == 1 && ratio_code == 3, "R7 two matches lock", ratio_code, 3);
    // R8 single glitch ignored
    frames(700, 1);
    frames(256, 1);
    check(locked == 1 && ratio_code == 3, "R8 single glitch kept", locked, 1);
    frames(256, 1);
    frames(700, 2);
    check(locked == 1, "R8 one bad still locked", locked, 1);
    frames(700, 1);
    check(locked == 0 && speed_mode == 0, "R8 two bad unlock", locked, 0);

    // R9 saturation: 2560 would wrap to 512
    frames(512, 6);
    check(locked == 1 && ratio_code == 5, "R9 pre-lock 512", ratio_code, 5);
    frames(2560, 3);
    check(locked == 0 && ratio_code == 0, "R9 long frame unsupported", ratio_code, 0);

    // R6 manual sweep
    auto_sel = 1'b0;
    for (int i = 2; i < 7; i++) begin
      frames(noms[i], 8);
      check(locked == 1 && ratio_code == i + 1, $sformatf("R6 manual code r=%0d", noms[i]),
            ratio_code, i + 1);
      check(speed_mode == 0, $sformatf("R6 manual speed r=%0d", noms[i]), speed_mode, 0);
    end
    frames(128, 8);
    check(locked == 0, "R6 manual rejects 128", locked, 0);
    frames(192, 8);
    check(locked == 0, "R6 manual rejects 192", locked, 0);
    auto_sel = 1'b1;
    frames(192, 8);
    check(locked == 1 && speed_mode == 2, "R5 auto 192 quad", speed_mode, 2);

    // R1 R2 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge mclk);
    check(locked == 0 && pwr_down == 1 && ratio_code == 0, "R1 reset mid-run",
          {locked, pwr_down}, 1);
    rst_n = 1'b1;
    repeat (30) @(negedge mclk);
    check(pwr_down == 1, "R2 pd after re-reset", pwr_down, 1);
    frames(256, 1);
    check(pwr_down == 0, "R2 pd clears again", pwr_down, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge mclk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule